// File: doc/BRIEF.md
# Configuration Transaction Controller

This block gives software three word registers: a data word, a control word and a status word. Software runs one configuration transaction at a time by writing the control word with its start bit set. The control word is split into channel, function, site, position and device fields. If the transaction is a read, a value from an internal lookup is loaded into the data word. If it is a write, the data word is stored into an oscillator table, or a one-cycle request pulse is raised. The status word then shows that the transaction completed, and it also flags an error when the transaction is not supported.

Two tables are held in flops. One is a six-entry main-board oscillator table with fixed reset frequencies. The other is a daughter-board oscillator table whose size and reset values are parameters. Voltage reads return a fixed main-board rail value, or a parameterised daughter-board sensor value. Shutdown and reboot requests leave the block as single-cycle pulses.

Top module: `cfgx_top`

## Requirements
- R1: After reset the data, control and status words read 0, both request outputs are low, and the main-board oscillator table holds 50000000, 23750000, 24000000, 24000000, 24000000, 24000000 for devices 0 to 5.
- R2: A write to the control word (offset 0xA4) stores the written value, except that bits 31 and 19:18 always read as 0. If bit 31 is clear, the write has no other effect.
- R3: A control write with bit 31 (start) set runs the transaction on that same write. From the next cycle the status word (offset 0xA8) reads 1 (complete), or 3 (complete plus error in bit 1) when the transaction is unsupported.
- R4: Field layout: bit 30 is write-not-read, bits 29:26 are the channel, bits 25:20 the function, bits 17:16 the site, bits 15:12 the position and bits 11:0 the device. A nonzero channel, a nonzero position, or a site other than 0 or 1 gives an error and leaves the data word unchanged.
- R5: An oscillator read (function 1) of site 0 with a device below 6 loads that main-board table entry into the data word (offset 0xA0).
- R6: An oscillator write stores the data word into the addressed entry: site 0 for the main board, site 1 for the daughter-board table of DB_OSC_N entries (reset values from DB_OSC_INIT). A later read returns the stored value.
- R7: A voltage read (function 2) of site 0, device 0 loads 3300000. A voltage read of site 1 with a device below DB_VS_N loads that entry of DB_VOLT. Any other voltage access, including a voltage write, is an error.
- R8: A shutdown write (function 8) or reboot write (function 9) to site 0, device 0 raises shutdownReq or rebootReq, respectively, for exactly the cycle after the write. Any other site, device or direction is an error and raises no pulse.
- R9: A video-mux select write (function 7) or DVI-mode write (function 11) to site 0, device 0 completes without error and changes nothing else. A read with either function is an error.
- R10: A write to the status word stores only bits 1:0 of the written value.
- R11: An oscillator access whose device is past the end of its table is an error, and it leaves both the table and the data word unchanged.
- R12: Reads of any offset other than 0xA0, 0xA4 and 0xA8 return 0, and writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` (combinational) |
| shutdownReq | output | 1 | One-cycle shutdown request |
| rebootReq | output | 1 | One-cycle reboot request |

## Verification
Every register update, including the whole transaction, takes effect on the clock edge that accepts the write. Because `rdData` is a combinational view of the registers, a result can be read back in the cycle right after that edge. The request pulses are registered, so they are high only in that following cycle and are low again one cycle later. The bench drives each write on a falling edge, reads back and samples the pulse outputs on the next falling edge, and checks that the pulse has dropped one cycle after that.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int DEV_W  = 12;
  localparam int MB_OSC_N = 6;

  localparam logic [ADDR_W-1:0] DATA_OFS = 8'hA0;
  localparam logic [ADDR_W-1:0] CTRL_OFS = 8'hA4;
  localparam logic [ADDR_W-1:0] STAT_OFS = 8'hA8;

  // bits 31 (start) and 19:18 (reserved) never stored
  localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h7FF3_FFFF;
  localparam logic [DATA_W-1:0] MB_VOLT_UV = 32'd3300000;

  localparam logic [5:0] FN_OSC    = 6'd1;
  localparam logic [5:0] FN_VOLT   = 6'd2;
  localparam logic [5:0] FN_VMUX   = 6'd7;
  localparam logic [5:0] FN_SHUT   = 6'd8;
  localparam logic [5:0] FN_REBOOT = 6'd9;
  localparam logic [5:0] FN_DVI    = 6'd11;

  typedef enum logic [1:0] {
    SRC_MB_OSC, SRC_DB_OSC, SRC_MB_VOLT, SRC_DB_VOLT
  } srcSel_e;

  typedef struct packed {
    logic             launch;
    logic             fail;
    logic             loadData;
    srcSel_e          src;
    logic             mbWr;
    logic             dbWr;
    logic [DEV_W-1:0] dev;
    logic             shutdown;
    logic             reboot;
  } xactStrobe_t;

  function automatic logic [DATA_W-1:0] mbOscInit(input int idx);
    if (idx == 0) return 32'd50000000;
    if (idx == 1) return 32'd23750000;
    return 32'd24000000;
  endfunction
endpackage

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
  import cfgx_pkg::*;
#(
  parameter int DB_OSC_N = 3,
  parameter int DB_VS_N  = 2
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output xactStrobe_t       stb
);
  localparam logic [DEV_W-1:0] MB_LIM = DEV_W'(MB_OSC_N);
  localparam logic [DEV_W-1:0] DB_LIM = DEV_W'(DB_OSC_N);
  localparam logic [DEV_W-1:0] VS_LIM = DEV_W'(DB_VS_N);

  logic             isWrite;
  logic [3:0]       chan;
  logic [5:0]       func;
  logic [1:0]       site;
  logic [3:0]       pos;
  logic [DEV_W-1:0] dev;
  logic             siteOk;
  logic             mainDev0;
  logic             okFlag;
  logic             unusedRsvd;

  assign isWrite    = wrData[30];
  assign chan       = wrData[29:26];
  assign func       = wrData[25:20];
  assign site       = wrData[17:16];
  assign pos        = wrData[15:12];
  assign dev        = wrData[DEV_W-1:0];
  assign unusedRsvd = ^wrData[19:18];

  assign siteOk   = (chan == 4'd0) && (pos == 4'd0) && (site <= 2'd1);
  assign mainDev0 = (site == 2'd0) && (dev == '0);

  always_comb begin
    stb        = '0;
    okFlag     = 1'b0;
    stb.launch = wrEn && (addr == CTRL_OFS) && wrData[31];
    stb.dev    = dev;
    if (stb.launch && siteOk) begin
      case (func)
        FN_OSC: begin
          if (site == 2'd0 && dev < MB_LIM) begin
            okFlag       = 1'b1;
            stb.mbWr     = isWrite;
            stb.loadData = !isWrite;
            stb.src      = SRC_MB_OSC;
          end else if (site == 2'd1 && dev < DB_LIM) begin
            okFlag       = 1'b1;
            stb.dbWr     = isWrite;
            stb.loadData = !isWrite;
            stb.src      = SRC_DB_OSC;
          end
        end
        FN_VOLT: begin
          if (!isWrite && mainDev0) begin
            okFlag       = 1'b1;
            stb.loadData = 1'b1;
            stb.src      = SRC_MB_VOLT;
          end else if (!isWrite && site == 2'd1 && dev < VS_LIM) begin
            okFlag       = 1'b1;
            stb.loadData = 1'b1;
            stb.src      = SRC_DB_VOLT;
          end
        end
        FN_VMUX, FN_DVI: okFlag = isWrite && mainDev0;
        FN_SHUT: begin
          okFlag       = isWrite && mainDev0;
          stb.shutdown = isWrite && mainDev0;
        end
        FN_REBOOT: begin
          okFlag     = isWrite && mainDev0;
          stb.reboot = isWrite && mainDev0;
        end
        default: okFlag = 1'b0;
      endcase
    end
    stb.fail = stb.launch && !okFlag;
  end
endmodule

// File: rtl/cfgx_datapath.sv
module cfgx_datapath
  import cfgx_pkg::*;
#(
  parameter int DB_OSC_N = 3,
  parameter int DB_VS_N  = 2,
  parameter logic [DB_OSC_N*DATA_W-1:0] DB_OSC_INIT = '0,
  parameter logic [DB_VS_N*DATA_W-1:0]  DB_VOLT     = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  xactStrobe_t       stb,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        cfgStat,
  output logic [DATA_W-1:0] cfgData,
  output logic              shutdownReq,
  output logic              rebootReq
);
  logic [DATA_W-1:0] cfgCtrl;
  logic [DATA_W-1:0] mbOsc [MB_OSC_N];
  logic [DATA_W-1:0] dbOsc [DB_OSC_N];
  logic [DATA_W-1:0] mbSel, dbSel, vsSel, lookVal;

  for (genvar g = 0; g < MB_OSC_N; g++) begin : g_mb
    always_ff @(posedge clk) begin
      if (!rstN) mbOsc[g] <= mbOscInit(g);
      else if (stb.mbWr && stb.dev == DEV_W'(g)) mbOsc[g] <= cfgData;
    end
  end

  for (genvar g = 0; g < DB_OSC_N; g++) begin : g_db
    always_ff @(posedge clk) begin
      if (!rstN) dbOsc[g] <= DB_OSC_INIT[g*DATA_W +: DATA_W];
      else if (stb.dbWr && stb.dev == DEV_W'(g)) dbOsc[g] <= cfgData;
    end
  end

  always_comb begin
    mbSel = '0;
    dbSel = '0;
    vsSel = '0;
    for (int i = 0; i < MB_OSC_N; i++) if (stb.dev == DEV_W'(i)) mbSel = mbOsc[i];
    for (int i = 0; i < DB_OSC_N; i++) if (stb.dev == DEV_W'(i)) dbSel = dbOsc[i];
    for (int i = 0; i < DB_VS_N; i++)
      if (stb.dev == DEV_W'(i)) vsSel = DB_VOLT[i*DATA_W +: DATA_W];
    case (stb.src)
      SRC_MB_OSC:  lookVal = mbSel;
      SRC_DB_OSC:  lookVal = dbSel;
      SRC_MB_VOLT: lookVal = MB_VOLT_UV;
      default:     lookVal = vsSel;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgData     <= '0;
      cfgCtrl     <= '0;
      cfgStat     <= '0;
      shutdownReq <= 1'b0;
      rebootReq   <= 1'b0;
    end else begin
      shutdownReq <= stb.shutdown;
      rebootReq   <= stb.reboot;
      if (stb.loadData) cfgData <= lookVal;
      else if (wrEn && addr == DATA_OFS) cfgData <= wrData;
      if (wrEn && addr == CTRL_OFS) cfgCtrl <= wrData & CTRL_KEEP;
      if (stb.launch) cfgStat <= {stb.fail, 1'b1};
      else if (wrEn && addr == STAT_OFS) cfgStat <= wrData[1:0];
    end
  end

  always_comb begin
    case (addr)
      DATA_OFS: rdData = cfgData;
      CTRL_OFS: rdData = cfgCtrl;
      STAT_OFS: rdData = {{(DATA_W-2){1'b0}}, cfgStat};
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/cfgx_top.sv
module cfgx_top
  import cfgx_pkg::*;
#(
  parameter int DB_OSC_N = 3,
  parameter int DB_VS_N  = 2,
  parameter logic [DB_OSC_N*32-1:0] DB_OSC_INIT =
    {32'd33000000, 32'd40000000, 32'd60000000},
  parameter logic [DB_VS_N*32-1:0] DB_VOLT = {32'd1000000, 32'd900000}
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        shutdownReq,
  output logic        rebootReq
);
  xactStrobe_t       stb;
  logic [1:0]        cfgStat;
  logic [DATA_W-1:0] cfgData;

  cfgx_ctrl #(.DB_OSC_N(DB_OSC_N), .DB_VS_N(DB_VS_N)) i_ctrl (
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .stb(stb)
  );

  cfgx_datapath #(
    .DB_OSC_N(DB_OSC_N), .DB_VS_N(DB_VS_N),
    .DB_OSC_INIT(DB_OSC_INIT), .DB_VOLT(DB_VOLT)
  ) i_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .stb(stb), .rdData(rdData), .cfgStat(cfgStat), .cfgData(cfgData),
    .shutdownReq(shutdownReq), .rebootReq(rebootReq)
  );
endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker
  import cfgx_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [7:0]  addr,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic        shutdownReq,
  input logic        rebootReq,
  input logic [1:0]  cfgStat,
  input logic [31:0] cfgData
);
  logic startWr;
  logic unusedRsvd;
  assign startWr    = wrEn && addr == CTRL_OFS && wrData[31];
  assign unusedRsvd = ^wrData[19:18];

  a_r2_ctrl_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr == CTRL_OFS) |-> (rdData[31] == 1'b0 && rdData[19:18] == 2'b00));

  a_r3_complete_after_start: assert property (@(posedge clk) disable iff (!rstN)
    startWr |=> cfgStat[0]);

  a_r4_bad_channel_error: assert property (@(posedge clk) disable iff (!rstN)
    (startWr && wrData[29:26] != 4'd0) |=> (cfgStat == 2'b11));

  a_r4_bad_channel_keeps_data: assert property (@(posedge clk) disable iff (!rstN)
    (startWr && !wrData[30] && wrData[29:26] != 4'd0) |=> $stable(cfgData));

  a_r8_shutdown_cause: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> $past(startWr && wrData[30] && wrData[29:26] == 4'd0 &&
                          wrData[25:20] == FN_SHUT && wrData[17:0] == 18'd0));

  a_r8_reboot_cause: assert property (@(posedge clk) disable iff (!rstN)
    rebootReq |-> $past(startWr && wrData[30] && wrData[29:26] == 4'd0 &&
                        wrData[25:20] == FN_REBOOT && wrData[17:0] == 18'd0));

  a_r10_status_store: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == STAT_OFS) |=> (cfgStat == $past(wrData[1:0])));

  a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr != DATA_OFS && addr != CTRL_OFS && addr != STAT_OFS) |-> (rdData == 32'd0));
endmodule

bind cfgx_top cfgx_checker i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .rdData(rdData), .shutdownReq(shutdownReq), .rebootReq(rebootReq),
  .cfgStat(cfgStat), .cfgData(cfgData)
);

// File: tb/test_cfgx_top.sv
module test_cfgx_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        shutdownReq, rebootReq;
  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  cfgx_top i_cfgx_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .shutdownReq(shutdownReq), .rebootReq(rebootReq)
  );

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] din;
    logic [31:0] dout;
    logic [1:0]  st;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{32'h80100000, 32'h0,      32'd50000000, 2'd1, 8'd5},  // R5 mb osc dev0
    '{32'h80100001, 32'h0,      32'd23750000, 2'd1, 8'd5},  // R5 dev1
    '{32'h80100005, 32'h0,      32'd24000000, 2'd1, 8'd5},  // R5 last entry
    '{32'h80110002, 32'h0,      32'd33000000, 2'd1, 8'd6},  // R6 db osc reset
    '{32'h80200000, 32'h0,      32'd3300000,  2'd1, 8'd7},  // R7 mb volt
    '{32'h80210001, 32'h0,      32'd1000000,  2'd1, 8'd7},  // R7 db volt
    '{32'h80200001, 32'h1234,   32'h1234,     2'd3, 8'd7},  // R7 bad mb sensor
    '{32'h84100000, 32'h55,     32'h55,       2'd3, 8'd4},  // R4 channel 1
    '{32'h80102000, 32'h66,     32'h66,       2'd3, 8'd4},  // R4 position 2
    '{32'h80120000, 32'h77,     32'h77,       2'd3, 8'd4},  // R4 site 2
    '{32'hC0100003, 32'd12345678, 32'd12345678, 2'd1, 8'd6}, // R6 write mb3
    '{32'h80100003, 32'h0,      32'd12345678, 2'd1, 8'd6},  // R6 read back
    '{32'h80100006, 32'h7,      32'h7,        2'd3, 8'd11}, // R11 mb dev6
    '{32'hC0110003, 32'd99,     32'd99,       2'd3, 8'd11}, // R11 db dev3
    '{32'h80110002, 32'h0,      32'd33000000, 2'd1, 8'd11}, // R11 db intact
    '{32'hC0700000, 32'h5,      32'h5,        2'd1, 8'd9},  // R9 mux write
    '{32'hC0B00000, 32'h6,      32'h6,        2'd1, 8'd9},  // R9 dvi write
    '{32'h80700000, 32'h8,      32'h8,        2'd3, 8'd9},  // R9 mux read
    '{32'hC0200000, 32'h9,      32'h9,        2'd3, 8'd7}   // R7 volt write
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; addr = 8'h00; wrData = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'hA0, v); chk("R1 data reset", v, 32'h0);
    rd(8'hA4, v); chk("R1 ctrl reset", v, 32'h0);
    rd(8'hA8, v); chk("R1 stat reset", v, 32'h0);
    chk("R1 shutdownReq reset", {31'b0, shutdownReq}, 32'h0);
    chk("R1 rebootReq reset", {31'b0, rebootReq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(8'hA0, VECS[i].din);
      wr(8'hA4, VECS[i].ctrl);
      rd(8'hA0, v); chk($sformatf("R%0d vec%0d data", VECS[i].req, i), v, VECS[i].dout);
      rd(8'hA8, v); chk($sformatf("R%0d vec%0d stat", VECS[i].req, i), v, {30'b0, VECS[i].st});
      rd(8'hA4, v); chk($sformatf("R2 vec%0d ctrl", i), v, VECS[i].ctrl & 32'h7FF3FFFF);
    end

    // R2 write without start: stored masked, status untouched (3 from last vector)
    wr(8'hA4, 32'h7FFFFFFF);
    rd(8'hA4, v); chk("R2 ctrl masked", v, 32'h7FF3FFFF);
    rd(8'hA8, v); chk("R2 no launch", v, 32'h3);

    // R10 status write keeps low two bits
    wr(8'hA8, 32'hFFFFFFFE);
    rd(8'hA8, v); chk("R10 status bits", v, 32'h2);

    // R8 shutdown pulse
    wr(8'hA4, 32'hC0800000);
    chk("R8 shutdown high", {31'b0, shutdownReq}, 32'h1);
    chk("R8 reboot quiet", {31'b0, rebootReq}, 32'h0);
    rd(8'hA8, v); chk("R3 shutdown status", v, 32'h1);
    @(negedge clk);
    chk("R8 shutdown one cycle", {31'b0, shutdownReq}, 32'h0);

    // R8 reboot pulse
    wr(8'hA4, 32'hC0900000);
    chk("R8 reboot high", {31'b0, rebootReq}, 32'h1);
    chk("R8 shutdown quiet", {31'b0, shutdownReq}, 32'h0);
    @(negedge clk);
    chk("R8 reboot one cycle", {31'b0, rebootReq}, 32'h0);

    // R8 shutdown to site 1 is refused
    wr(8'hA4, 32'hC0810000);
    chk("R8 bad site no pulse", {31'b0, shutdownReq}, 32'h0);
    rd(8'hA8, v); chk("R8 bad site error", v, 32'h3);

    // R12 unmapped offsets
    wr(8'hA0, 32'hCAFE0001);
    wr(8'h10, 32'hFFFFFFFF);
    rd(8'h10, v); chk("R12 unmapped reads zero", v, 32'h0);
    rd(8'hA0, v); chk("R12 data untouched", v, 32'hCAFE0001);
    rd(8'hA4, v); chk("R12 ctrl untouched", v, 32'h40810000);

    finish_run();
  end
endmodule